// File: doc/BRIEF.md
# Interprocessor event unit

This block sits inside a processing element and carries short asynchronous event notices between processors. A processor starts a notice by storing four words into a small memory-mapped window: the target element, an event code and two data words. Storing the last word launches the notice, which leaves the unit as a stream of four words on a RDY/ACK link toward the node interface unit. The first word is a header that carries an event type tag, so the node interface can tell this traffic apart from memory requests and replies.

On the receiving side the unit takes the same four-word stream from the node interface. It keeps the event code and the two data words in a single-entry holding buffer, and it raises an interrupt request toward its own processor. The request and its three values stay steady until the processor acknowledges. Nothing is ever sent back to the sender. While the buffer is occupied, the input link is not acknowledged, so further notices wait in the network.

A word moves on either link in any cycle where the sender's RDY and the receiver's ACK are both high.

Top module: `ipe_event_unit`

## Requirements
- R1: After reset `net_tx_rdy`, `irq_req` and `cpu_wr_stall` are low and `net_rx_ack` is high.
- R2: A store at window offset 0 records the target element from bits 5:0 of the store data, and any upper bits are dropped. A store at offset 1 records the event code and a store at offset 2 records the first data word. None of these three stores puts anything on the output link.
- R3: A store at offset 3 records the second data word and starts a notice. The output link then carries exactly four words in this order: header, event code, first data word, second data word.
- R4: The header word has the event tag 2'b10 in bits 31:30, the target element in bits 5:0, and zeros in all other bits.
- R5: An output word is taken only in a cycle where `net_tx_rdy` and `net_tx_ack` are both high. While it waits for ACK, `net_tx_word` holds steady.
- R6: While a notice is being sent, `cpu_wr_stall` is high and stores are not accepted. They leave the window contents untouched. The stall drops in the cycle after the last word is taken.
- R7: On the input link a header with tag 2'b10 in bits 31:30 is followed by code, parameter 1 and parameter 2. In the cycle after the fourth word is taken, `irq_req` rises with `irq_code`, `irq_param1` and `irq_param2` set to those three words.
- R8: When the unit is waiting for a header, a word whose bits 31:30 are not 2'b10 is taken and discarded without effect.
- R9: `net_rx_ack` is low whenever an interrupt is pending. The next incoming notice then waits on the link.
- R10: `irq_req` and its three values stay steady until `irq_ack` is seen high. `irq_req` drops in the following cycle.
- R11: Receiving a notice never produces traffic on the output link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Store to the register window |
| cpu_wr_off | input | 2 | Window offset of the store |
| cpu_wr_data | input | 32 | Store data |
| cpu_wr_stall | output | 1 | Store not accepted this cycle |
| net_tx_rdy | output | 1 | Output word valid |
| net_tx_word | output | 32 | Output word |
| net_tx_ack | input | 1 | Output word taken by node interface |
| net_rx_rdy | input | 1 | Input word valid |
| net_rx_word | input | 32 | Input word |
| net_rx_ack | output | 1 | Input word taken by this unit |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| irq_code | output | 32 | Event code of the pending notice |
| irq_param1 | output | 32 | First parameter of the pending notice |
| irq_param2 | output | 32 | Second parameter of the pending notice |

## Verification
Several rules are checked by the assertions on every cycle:
- output words stay steady under back-pressure;
- a notice starts only after an offset-3 store;
- the input link is blocked while an interrupt is pending;
- the interrupt and its values hold until acknowledged, and then release one cycle later.

Other behaviour needs the bench scenarios:
- the exact word order and header layout;
- that stores issued during a stall leave the window contents untouched;
- that wrongly tagged words are discarded;
- that receiving produces no output traffic.

Those scenarios include heavy back-pressure, back-to-back notices, and sending and receiving at the same time.

// File: rtl/ipe_pkg.sv
package ipe_pkg;
    localparam int unsigned MSG_WORDS = 4;
    localparam int unsigned OFF_W     = $clog2(MSG_WORDS);

    localparam logic [OFF_W-1:0] OFF_TARGET = 2'd0;
    localparam logic [OFF_W-1:0] OFF_CODE   = 2'd1;
    localparam logic [OFF_W-1:0] OFF_DATA1  = 2'd2;
    localparam logic [OFF_W-1:0] OFF_DATA2  = 2'd3;

    typedef enum logic [1:0] {
        BEAT_HDR  = 2'd0,
        BEAT_CODE = 2'd1,
        BEAT_D1   = 2'd2,
        BEAT_D2   = 2'd3
    } beat_e;
endpackage

// File: rtl/ipe_tx.sv
module ipe_tx
    import ipe_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PE_ID_W = 6,
    parameter int unsigned TAG_W   = 2,
    parameter logic [TAG_W-1:0] TAG_VAL = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_stall,
    output logic              tx_rdy,
    output logic [DATA_W-1:0] tx_word,
    input  logic              tx_ack
);
    typedef struct packed {
        logic               busy;
        beat_e              beat;
        logic [PE_ID_W-1:0] target;
        logic [DATA_W-1:0]  code;
        logic [DATA_W-1:0]  data1;
        logic [DATA_W-1:0]  data2;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [DATA_W-1:0] hdr_word;

    always_comb begin
        hdr_word = '0;
        hdr_word[DATA_W-1 -: TAG_W] = TAG_VAL;
        hdr_word[PE_ID_W-1:0]       = st_q.target;
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.busy && wr_en) begin
            unique case (wr_off)
                OFF_TARGET: st_d.target = wr_data[PE_ID_W-1:0];
                OFF_CODE:   st_d.code   = wr_data;
                OFF_DATA1:  st_d.data1  = wr_data;
                default: begin
                    st_d.data2 = wr_data;
                    st_d.busy  = 1'b1;
                    st_d.beat  = BEAT_HDR;
                end
            endcase
        end
        if (st_q.busy && tx_ack) begin
            unique case (st_q.beat)
                BEAT_HDR:  st_d.beat = BEAT_CODE;
                BEAT_CODE: st_d.beat = BEAT_D1;
                BEAT_D1:   st_d.beat = BEAT_D2;
                default:   st_d.busy = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, beat: BEAT_HDR, target: '0,
                      code: '0, data1: '0, data2: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.beat)
            BEAT_HDR:  tx_word = hdr_word;
            BEAT_CODE: tx_word = st_q.code;
            BEAT_D1:   tx_word = st_q.data1;
            default:   tx_word = st_q.data2;
        endcase
    end

    assign tx_rdy   = st_q.busy;
    assign wr_stall = st_q.busy;
endmodule

// File: rtl/ipe_rx.sv
module ipe_rx
    import ipe_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 2,
    parameter logic [TAG_W-1:0] TAG_VAL = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_rdy,
    input  logic [DATA_W-1:0] rx_word,
    output logic              rx_ack,
    input  logic              buf_full,
    output logic              msg_load,
    output logic [DATA_W-1:0] msg_code,
    output logic [DATA_W-1:0] msg_p1,
    output logic [DATA_W-1:0] msg_p2
);
    typedef struct packed {
        beat_e             beat;
        logic [DATA_W-1:0] code;
        logic [DATA_W-1:0] p1;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic take;

    assign rx_ack = !buf_full;
    assign take   = rx_rdy && !buf_full;

    always_comb begin
        st_d     = st_q;
        msg_load = 1'b0;
        if (take) begin
            unique case (st_q.beat)
                BEAT_HDR: begin
                    if (rx_word[DATA_W-1 -: TAG_W] == TAG_VAL) st_d.beat = BEAT_CODE;
                end
                BEAT_CODE: begin
                    st_d.code = rx_word;
                    st_d.beat = BEAT_D1;
                end
                BEAT_D1: begin
                    st_d.p1   = rx_word;
                    st_d.beat = BEAT_D2;
                end
                default: begin
                    msg_load  = 1'b1;
                    st_d.beat = BEAT_HDR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{beat: BEAT_HDR, code: '0, p1: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_code = st_q.code;
    assign msg_p1   = st_q.p1;
    assign msg_p2   = rx_word;
endmodule

// File: rtl/ipe_irq.sv
module ipe_irq #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_code,
    input  logic [DATA_W-1:0] in_p1,
    input  logic [DATA_W-1:0] in_p2,
    output logic              full,
    output logic              irq_req,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] irq_code,
    output logic [DATA_W-1:0] irq_p1,
    output logic [DATA_W-1:0] irq_p2
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] code;
        logic [DATA_W-1:0] p1;
        logic [DATA_W-1:0] p2;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.full && irq_ack) st_d.full = 1'b0;
        if (load && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.code = in_code;
            st_d.p1   = in_p1;
            st_d.p2   = in_p2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{full: 1'b0, code: '0, p1: '0, p2: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign full     = st_q.full;
    assign irq_req  = st_q.full;
    assign irq_code = st_q.code;
    assign irq_p1   = st_q.p1;
    assign irq_p2   = st_q.p2;
endmodule

// File: rtl/ipe_event_unit.sv
module ipe_event_unit
    import ipe_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PE_ID_W = 6,
    parameter int unsigned TAG_W   = 2,
    parameter logic [TAG_W-1:0] TAG_VAL = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [OFF_W-1:0]  cpu_wr_off,
    input  logic [DATA_W-1:0] cpu_wr_data,
    output logic              cpu_wr_stall,
    output logic              net_tx_rdy,
    output logic [DATA_W-1:0] net_tx_word,
    input  logic              net_tx_ack,
    input  logic              net_rx_rdy,
    input  logic [DATA_W-1:0] net_rx_word,
    output logic              net_rx_ack,
    output logic              irq_req,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] irq_code,
    output logic [DATA_W-1:0] irq_param1,
    output logic [DATA_W-1:0] irq_param2
);
    logic              buf_full;
    logic              msg_load;
    logic [DATA_W-1:0] msg_code, msg_p1, msg_p2;

    ipe_tx #(.DATA_W(DATA_W), .PE_ID_W(PE_ID_W), .TAG_W(TAG_W), .TAG_VAL(TAG_VAL)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr_en),
        .wr_off   (cpu_wr_off),
        .wr_data  (cpu_wr_data),
        .wr_stall (cpu_wr_stall),
        .tx_rdy   (net_tx_rdy),
        .tx_word  (net_tx_word),
        .tx_ack   (net_tx_ack)
    );

    ipe_rx #(.DATA_W(DATA_W), .TAG_W(TAG_W), .TAG_VAL(TAG_VAL)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_rdy   (net_rx_rdy),
        .rx_word  (net_rx_word),
        .rx_ack   (net_rx_ack),
        .buf_full (buf_full),
        .msg_load (msg_load),
        .msg_code (msg_code),
        .msg_p1   (msg_p1),
        .msg_p2   (msg_p2)
    );

    ipe_irq #(.DATA_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (msg_load),
        .in_code  (msg_code),
        .in_p1    (msg_p1),
        .in_p2    (msg_p2),
        .full     (buf_full),
        .irq_req  (irq_req),
        .irq_ack  (irq_ack),
        .irq_code (irq_code),
        .irq_p1   (irq_param1),
        .irq_p2   (irq_param2)
    );
endmodule

// File: rtl/ipe_event_unit_chk.sv
module ipe_event_unit_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr_en,
    input logic [1:0]        cpu_wr_off,
    input logic              cpu_wr_stall,
    input logic              net_tx_rdy,
    input logic [DATA_W-1:0] net_tx_word,
    input logic              net_tx_ack,
    input logic              net_rx_rdy,
    input logic              net_rx_ack,
    input logic              irq_req,
    input logic              irq_ack,
    input logic [DATA_W-1:0] irq_code,
    input logic [DATA_W-1:0] irq_param1,
    input logic [DATA_W-1:0] irq_param2
);
    AST_TX_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        net_tx_rdy && !net_tx_ack |=> net_tx_rdy && $stable(net_tx_word)); // R5

    AST_TX_START_BY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(net_tx_rdy) |-> $past(cpu_wr_en && cpu_wr_off == 2'd3 && !cpu_wr_stall)); // R3

    AST_STALL_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_wr_stall) |-> $past(net_tx_ack)); // R6

    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !net_rx_ack); // R9

    AST_IRQ_RISE_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(net_rx_rdy && net_rx_ack)); // R7

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req && $stable(irq_code)
                                && $stable(irq_param1) && $stable(irq_param2)); // R10

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> !irq_req); // R10
endmodule

bind ipe_event_unit ipe_event_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_en    (cpu_wr_en),
    .cpu_wr_off   (cpu_wr_off),
    .cpu_wr_stall (cpu_wr_stall),
    .net_tx_rdy   (net_tx_rdy),
    .net_tx_word  (net_tx_word),
    .net_tx_ack   (net_tx_ack),
    .net_rx_rdy   (net_rx_rdy),
    .net_rx_ack   (net_rx_ack),
    .irq_req      (irq_req),
    .irq_ack      (irq_ack),
    .irq_code     (irq_code),
    .irq_param1   (irq_param1),
    .irq_param2   (irq_param2)
);

// File: tb/tb_ipe_event_unit.sv
`timescale 1ns/1ps
module tb_ipe_event_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [1:0]  cpu_wr_off = '0;
    logic [31:0] cpu_wr_data = '0;
    logic        cpu_wr_stall;
    logic        net_tx_rdy;
    logic [31:0] net_tx_word;
    logic        net_tx_ack = 1'b1;
    logic        net_rx_rdy = 1'b0;
    logic [31:0] net_rx_word = '0;
    logic        net_rx_ack;
    logic        irq_req;
    logic        irq_ack = 1'b0;
    logic [31:0] irq_code, irq_param1, irq_param2;

    always #4 clk = ~clk;

    ipe_event_unit dut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit bp_on   = 1'b0;
    int irq_delay = 2;

    logic [31:0] exp_tx[$];
    typedef struct packed { logic [31:0] code, p1, p2; } ev_t;
    ev_t exp_ev[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] hdr(input logic [5:0] tgt);
        return {2'b10, 24'h0, tgt};
    endfunction

    // back-pressure on the output link, changed away from both edges
    always @(posedge clk) begin
        #2;
        cyc++;
        net_tx_ack = bp_on ? (cyc % 3 != 0) : 1'b1;
    end

    // output-link monitor
    logic        hold_pend = 1'b0;
    logic [31:0] hold_word;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && net_tx_rdy)
                chk(net_tx_word == hold_word, "R5", "word held while waiting", net_tx_word, hold_word);
            hold_pend = 1'b0;
            if (net_tx_rdy && net_tx_ack) begin
                if (exp_tx.size() == 0)
                    chk(1'b0, "R11", "unexpected output word", net_tx_word, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_tx.pop_front();
                    chk(net_tx_word == e, "R3", "output word (R4 header)", net_tx_word, e);
                end
            end else if (net_tx_rdy) begin
                hold_pend = 1'b1;
                hold_word = net_tx_word;
            end
        end
    end

    // interrupt-side monitor acting as the processor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && irq_req) begin
                if (exp_ev.size() == 0)
                    chk(1'b0, "R8", "unexpected interrupt", irq_code, 32'h0);
                else begin
                    ev_t e;
                    e = exp_ev.pop_front();
                    chk(irq_code == e.code, "R7", "irq code", irq_code, e.code);
                    chk(irq_param1 == e.p1, "R7", "irq param1", irq_param1, e.p1);
                    chk(irq_param2 == e.p2, "R7", "irq param2", irq_param2, e.p2);
                    for (int i = 0; i < irq_delay; i++) begin
                        @(negedge clk);
                        chk(irq_req && irq_code == e.code && irq_param2 == e.p2,
                            "R10", "irq held until ack", irq_code, e.code);
                        chk(!net_rx_ack, "R9", "input blocked while pending", {31'h0, net_rx_ack}, 32'h0);
                    end
                end
                irq_ack = 1'b1;
                @(negedge clk);
                irq_ack = 1'b0;
                chk(!irq_req, "R10", "irq drops after ack", {31'h0, irq_req}, 32'h0);
            end
        end
    end

    task automatic cpu_store(input logic [1:0] off, input logic [31:0] d);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_off = off; cpu_wr_data = d;
        while (cpu_wr_stall) @(negedge clk);
        @(posedge clk);
        #1 cpu_wr_en = 1'b0;
    endtask

    task automatic cpu_msg(input logic [31:0] tgt, input logic [31:0] c,
                           input logic [31:0] d1, input logic [31:0] d2);
        exp_tx.push_back(hdr(tgt[5:0]));
        exp_tx.push_back(c);
        exp_tx.push_back(d1);
        exp_tx.push_back(d2);
        cpu_store(2'd0, tgt);
        cpu_store(2'd1, c);
        cpu_store(2'd2, d1);
        cpu_store(2'd3, d2);
    endtask

    task automatic rx_word(input logic [31:0] w);
        @(negedge clk);
        net_rx_rdy = 1'b1; net_rx_word = w;
        while (!net_rx_ack) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic rx_msg(input logic [5:0] tgt, input logic [31:0] c,
                          input logic [31:0] p1, input logic [31:0] p2);
        exp_ev.push_back('{code: c, p1: p1, p2: p2});
        rx_word(hdr(tgt));
        rx_word(c);
        rx_word(p1);
        rx_word(p2);
        #1 net_rx_rdy = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_tx.size() != 0 || exp_ev.size() != 0 || irq_req || net_tx_rdy) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 2000, "R3", "queues drained", t, 0);
    endtask

    initial begin
        #800000;
        chk(1'b0, "R1", "watchdog expired", 0, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!net_tx_rdy, "R1", "tx_rdy after reset", {31'h0, net_tx_rdy}, 0);
        chk(!irq_req, "R1", "irq_req after reset", {31'h0, irq_req}, 0);
        chk(!cpu_wr_stall, "R1", "stall after reset", {31'h0, cpu_wr_stall}, 0);
        chk(net_rx_ack, "R1", "rx_ack after reset", {31'h0, net_rx_ack}, 1);

        // R2: first three stores send nothing; upper target bits dropped (R4)
        cpu_store(2'd0, 32'hFFFF_FFC5);
        cpu_store(2'd1, 32'hC0DE_0001);
        cpu_store(2'd2, 32'h1111_2222);
        repeat (4) @(negedge clk);
        chk(!net_tx_rdy, "R2", "no output before offset 3", {31'h0, net_tx_rdy}, 0);
        exp_tx.push_back(hdr(6'h05));
        exp_tx.push_back(32'hC0DE_0001);
        exp_tx.push_back(32'h1111_2222);
        exp_tx.push_back(32'h3333_4444);
        cpu_store(2'd3, 32'h3333_4444);
        @(negedge clk);
        chk(cpu_wr_stall, "R6", "stall while sending", {31'h0, cpu_wr_stall}, 1);
        while (exp_tx.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(!cpu_wr_stall, "R6", "stall released after last word", {31'h0, cpu_wr_stall}, 0);

        // R5/R6: back-pressure, back-to-back notices
        bp_on = 1'b1;
        cpu_msg(32'h2A, 32'hAAAA_0001, 32'hAAAA_0002, 32'hAAAA_0003);
        cpu_msg(32'h3F, 32'hBBBB_0001, 32'hBBBB_0002, 32'hBBBB_0003);
        // R6: a store issued only while stalled is not taken
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_off = 2'd1; cpu_wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(cpu_wr_stall, "R6", "store issued during stall", {31'h0, cpu_wr_stall}, 1);
        cpu_wr_en = 1'b0;
        while (exp_tx.size() != 0) @(negedge clk);
        exp_tx.push_back(hdr(6'h3F));
        exp_tx.push_back(32'hBBBB_0001);
        exp_tx.push_back(32'hBBBB_0002);
        exp_tx.push_back(32'hCCCC_0009);
        cpu_store(2'd3, 32'hCCCC_0009);
        drain();
        bp_on = 1'b0;

        // R7/R11: receive a notice, no output traffic
        irq_delay = 3;
        rx_msg(6'h01, 32'h0000_0E01, 32'h5555_AAAA, 32'h0F0F_F0F0);
        drain();
        chk(!net_tx_rdy, "R11", "no reply after receive", {31'h0, net_tx_rdy}, 0);

        // R8: wrongly tagged word discarded before a real notice
        rx_word(32'h4000_0002);
        rx_word(32'h0000_0007);
        rx_msg(6'h02, 32'h0000_0E02, 32'h1234_5678, 32'h9ABC_DEF0);
        drain();

        // R9: second notice waits while first interrupt pending
        irq_delay = 6;
        fork
            begin
                rx_msg(6'h03, 32'h0000_0E03, 32'h0000_0031, 32'h0000_0032);
                rx_msg(6'h04, 32'h0000_0E04, 32'h0000_0041, 32'h0000_0042);
            end
            begin
                bp_on = 1'b1;
                cpu_msg(32'h07, 32'h7777_0001, 32'h7777_0002, 32'h7777_0003);
            end
        join
        drain();
        bp_on = 1'b0;
        chk(net_rx_ack && !irq_req, "R9", "input reopened at end", {31'h0, net_rx_ack}, 1);
        finish_run();
    end
endmodule